// File: doc/BRIEF.md
# Triggered pipeline readout serializer

This block is the digital half of a many-channel front-end readout. On every clock it stores one 8-bit sample from each of 128 channels into one column of a 160-column circular pipeline. When a first-level trigger accept arrives, the block picks the column that was filled a programmable number of writes earlier. It places that column in a 16-entry derandomizing queue, so bursts of triggers are absorbed.

Queued events leave one at a time as 36-cycle frames on four parallel 8-bit lanes. Each frame starts with four header cycles that carry the column address. Lane k then carries its own group of 32 channels. Columns that are waiting in the queue, or are being read out, are locked. The write pointer steps over them, so their samples survive until the frame that needs them has finished. The host keeps the average trigger rate at or below one event per 36 clocks. The busy and overflow outputs show whether that limit was broken.

Top module: `trig_pipe_serializer`

## Requirements
- R1: After reset, lane_valid, busy_o and ovf_o are low, lane_dout is zero and the queue is empty. The first write after reset goes to column 0.
- R2: On each clock out of reset, the whole sample bus is written into the column at the write pointer. The pointer then moves to the next column, counting upward modulo 160, that is not locked.
- R3: A trigger on a clock selects column (W − L) mod 160. W is the column written on that same clock and L is lat_i, valid from 1 to 159.
- R4: The queue holds 16 pending events. A trigger that arrives when 16 events are pending before that clock is dropped, even if an event leaves on that clock. A dropped trigger sets ovf_o, and ovf_o stays high until reset.
- R5: A column is locked while it is pending in the queue, while its frame is in progress (up to and including the last frame cycle), and on the clock on which a trigger selects it. Samples in a locked column are never overwritten.
- R6: A frame is 36 consecutive cycles with lane_valid high. When the block is idle, the frame becomes visible one clock after the clock that accepted the trigger.
- R7: In frame cycle h, for h from 0 to 3, every lane outputs the 2-bit field of the column address at bits [7−2h : 6−2h], zero-extended to 8 bits. The field is sent most significant first.
- R8: In frame cycle 4+i, lane k (bits [8k+7:8k] of lane_dout) outputs the stored sample of channel 32k+i. Channel j is taken from bits [8j+7:8j] of samp_i.
- R9: If another event is pending when a frame ends, the next frame starts on the next clock, with no idle cycle in between.
- R10: busy_o is high exactly when the queue is not empty or a frame is in progress.
- R11: Events leave in the order in which their triggers were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | 1024 | One 8-bit sample per channel, channel j at bits [8j+7:8j] |
| trig_i | input | 1 | Trigger accept strobe, one clock per trigger |
| lat_i | input | 8 | Trigger latency in columns, 1 to 159, held stable while triggers arrive |
| lane_dout | output | 32 | Four 8-bit lanes, lane k at bits [8k+7:8k] |
| lane_valid | output | 1 | High during every cycle of a frame |
| busy_o | output | 1 | Queue not empty or frame in progress |
| ovf_o | output | 1 | Sticky flag: a trigger was dropped |

## Verification
Faults in the write pointer, in the lock mask or in the latency arithmetic do not show up at once. They surface as wrong samples in a frame that may leave hundreds of clocks after the trigger, once the pointer has wrapped onto a column that should have been locked. The header shows which column was actually read. A wrong queue count or a wrong frame counter shows up sooner: lane_valid, busy_o or ovf_o change on the wrong clock, usually within one frame length. The bench therefore models the whole pointer, lock and queue state every clock and compares every lane on every frame cycle.

// File: rtl/trs_pkg.sv
package trs_pkg;

  // Column that lies lat writes behind wr on a ring of depth columns.
  function automatic int unsigned col_back(int unsigned wr, int unsigned lat,
                                           int unsigned depth);
    return (wr + depth - (lat % depth)) % depth;
  endfunction

  // Column n steps ahead of c on the ring.
  function automatic int unsigned col_fwd(int unsigned c, int unsigned n,
                                          int unsigned depth);
    return (c + n) % depth;
  endfunction

  // 2-bit address field sent in header cycle h (most significant first).
  function automatic int unsigned hdr_pair(int unsigned col, int unsigned h,
                                           int unsigned hdr);
    return (col >> (2 * (hdr - 1 - h))) & 3;
  endfunction

endpackage

// File: rtl/tps_pipeline.sv
module tps_pipeline
  import trs_pkg::*;
#(
  parameter int NCH   = 128,
  parameter int SW    = 8,
  parameter int DEPTH = 160,
  parameter int DQ    = 16,
  parameter int LANES = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int CPL   = NCH / LANES,
  parameter int IW    = $clog2(CPL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*SW-1:0]     samp_i,
  input  logic [DEPTH-1:0]      lock_i,
  output logic [AW-1:0]         wr_col_o,
  input  logic [AW-1:0]         rd_col_i,
  input  logic [IW-1:0]         rd_idx_i,
  output logic [LANES*SW-1:0]   rd_samp_o
);
  // Worst case locks: DQ pending, one active, one newly selected.
  localparam int SEARCH = DQ + 3;

  logic [NCH*SW-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q;
  logic [AW-1:0]     wr_nxt;
  logic              nxt_found;

  always_comb begin
    int unsigned c;
    wr_nxt    = wr_q;
    nxt_found = 1'b0;
    for (int s = 1; s <= SEARCH; s++) begin
      c = col_fwd(int'(wr_q), s, DEPTH);
      if (!nxt_found && !lock_i[c]) begin
        wr_nxt    = AW'(c);
        nxt_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= '0;
    else        wr_q <= wr_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst_n) mem[wr_q] <= samp_i;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_samp_o[l*SW +: SW] = mem[rd_col_i][(l*CPL + int'(rd_idx_i))*SW +: SW];
    end
  end

  assign wr_col_o = wr_q;

  a_r2_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_q) < DEPTH);
  a_r5_skip_found: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_found);

endmodule

// File: rtl/tps_derand.sv
module tps_derand #(
  parameter int AW = 8,
  parameter int DQ = 16,
  parameter int CW = $clog2(DQ + 1),
  parameter int PW = $clog2(DQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic [AW-1:0]       col_i,
  input  logic                pop_i,
  output logic                accept_o,
  output logic [AW-1:0]       head_o,
  output logic                empty_o,
  output logic                ovf_o,
  output logic [DQ-1:0][AW-1:0] ent_o,
  output logic [DQ-1:0]       vld_o
);
  logic [DQ-1:0][AW-1:0] ent_q;
  logic [DQ-1:0]         vld_q;
  logic [PW-1:0]         rp_q, wp_q;
  logic [CW-1:0]         cnt_q;
  logic                  ovf_q;
  logic                  full;

  assign full     = (cnt_q == CW'(DQ));
  assign accept_o = push_i && !full;
  assign empty_o  = (cnt_q == '0);
  assign head_o   = ent_q[rp_q];

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (int'(p) == DQ - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      vld_q <= '0;
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (pop_i) begin
        vld_q[rp_q] <= 1'b0;
        rp_q        <= ptr_inc(rp_q);
      end
      if (accept_o) begin
        ent_q[wp_q] <= col_i;
        vld_q[wp_q] <= 1'b1;
        wp_q        <= ptr_inc(wp_q);
      end
      cnt_q <= cnt_q + CW'(accept_o) - CW'(pop_i);
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;
  assign ent_o = ent_q;
  assign vld_o = vld_q;

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DQ);
  a_r4_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !accept_o) |=> ovf_q);
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  a_r4_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));

endmodule

// File: rtl/tps_framer.sv
module tps_framer
  import trs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int SW    = 8,
  parameter int LANES = 4,
  parameter int HDR   = 4,
  parameter int CPL   = 32,
  parameter int FR    = HDR + CPL,
  parameter int CW    = $clog2(FR),
  parameter int IW    = $clog2(CPL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                empty_i,
  input  logic [AW-1:0]       head_i,
  output logic                pop_o,
  output logic                active_o,
  output logic [AW-1:0]       cur_col_o,
  output logic [IW-1:0]       rd_idx_o,
  input  logic [LANES*SW-1:0] samp_i,
  output logic [LANES*SW-1:0] lane_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] cur_q;
  logic          last_cyc;
  logic          in_hdr;

  assign last_cyc = active_q && (cnt_q == CW'(FR - 1));
  assign pop_o    = (!active_q || last_cyc) && !empty_i;
  assign in_hdr   = (cnt_q < CW'(HDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
    end else if (pop_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      cur_q    <= head_i;
    end else if (last_cyc) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign rd_idx_o  = in_hdr ? '0 : IW'(cnt_q - CW'(HDR));
  assign active_o  = active_q;
  assign cur_col_o = cur_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (!active_q)   lane_o[l*SW +: SW] = '0;
      else if (in_hdr) lane_o[l*SW +: SW] = SW'(hdr_pair(int'(cur_q), int'(cnt_q), HDR));
      else             lane_o[l*SW +: SW] = samp_i[l*SW +: SW];
    end
  end

  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (int'(cnt_q) < FR));
  a_r6_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last_cyc) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));
  a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && !empty_i) |=> (active_q && cnt_q == '0));
  a_r6_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !empty_i) |=> (active_q && cnt_q == '0));

endmodule

// File: rtl/trig_pipe_serializer.sv
module trig_pipe_serializer
  import trs_pkg::*;
#(
  parameter int NCH   = 128,
  parameter int SW    = 8,
  parameter int DEPTH = 160,
  parameter int LANES = 4,
  parameter int HDR   = 4,
  parameter int DQ    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*SW-1:0]   samp_i,
  input  logic                trig_i,
  input  logic [AW-1:0]       lat_i,
  output logic [LANES*SW-1:0] lane_dout,
  output logic                lane_valid,
  output logic                busy_o,
  output logic                ovf_o
);
  localparam int CPL = NCH / LANES;
  localparam int IW  = $clog2(CPL);

  logic [AW-1:0]         wr_col;
  logic [AW-1:0]         tgt_col;
  logic [DEPTH-1:0]      lock;
  logic                  accept;
  logic                  pop;
  logic                  q_empty;
  logic [AW-1:0]         q_head;
  logic [DQ-1:0][AW-1:0] q_ent;
  logic [DQ-1:0]         q_vld;
  logic                  active;
  logic [AW-1:0]         cur_col;
  logic [IW-1:0]         rd_idx;
  logic [LANES*SW-1:0]   rd_samp;

  assign tgt_col = AW'(col_back(int'(wr_col), int'(lat_i), DEPTH));

  // Columns the write pointer must not land on at the coming edge.
  always_comb begin
    lock = '0;
    for (int i = 0; i < DQ; i++) begin
      if (q_vld[i]) lock[q_ent[i]] = 1'b1;
    end
    if (active) lock[cur_col] = 1'b1;
    if (accept) lock[tgt_col] = 1'b1;
  end

  tps_pipeline #(
    .NCH(NCH), .SW(SW), .DEPTH(DEPTH), .DQ(DQ), .LANES(LANES), .AW(AW)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_i    (samp_i),
    .lock_i    (lock),
    .wr_col_o  (wr_col),
    .rd_col_i  (cur_col),
    .rd_idx_i  (rd_idx),
    .rd_samp_o (rd_samp)
  );

  tps_derand #(.AW(AW), .DQ(DQ)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (trig_i),
    .col_i    (tgt_col),
    .pop_i    (pop),
    .accept_o (accept),
    .head_o   (q_head),
    .empty_o  (q_empty),
    .ovf_o    (ovf_o),
    .ent_o    (q_ent),
    .vld_o    (q_vld)
  );

  tps_framer #(
    .AW(AW), .SW(SW), .LANES(LANES), .HDR(HDR), .CPL(CPL)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .empty_i   (q_empty),
    .head_i    (q_head),
    .pop_o     (pop),
    .active_o  (active),
    .cur_col_o (cur_col),
    .rd_idx_o  (rd_idx),
    .samp_i    (rd_samp),
    .lane_o    (lane_dout)
  );

  assign lane_valid = active;
  assign busy_o     = active || !q_empty;

  a_r5_write_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock[wr_col]);
  a_r10_valid_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> busy_o);
  a_r11_pop_takes_head: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (cur_col == $past(q_head)));
  a_r3_target_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (tgt_col != wr_col));

endmodule

// File: tb/trig_pipe_serializer_tb.sv
module trig_pipe_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 128;
  localparam int DEPTH = 160;
  localparam int DQ = 16;
  localparam int FR = 36;
  localparam int CPL = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH*8-1:0] samp_i;
  logic             trig_i;
  logic [7:0]       lat_i;
  logic [31:0]      lane_dout;
  logic             lane_valid, busy_o, ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_pipe_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .trig_i(trig_i), .lat_i(lat_i),
    .lane_dout(lane_dout), .lane_valid(lane_valid), .busy_o(busy_o), .ovf_o(ovf_o)
  );

  typedef struct { int col; int k; } ev_t;

  ev_t pend[$];          // scoreboard of accepted, not yet started events
  ev_t act_it;
  bit  m_act;
  int  m_cnt;
  bit  m_ovf;
  int  m_wr;
  int  colk [DEPTH];     // write index last stored in each column
  int  kk;
  int  n_chk = 0;
  int  n_fail = 0;

  function automatic logic [7:0] pat(int k, int ch);
    return 8'((k * 37 + ch * 11 + (k >> 3) * 5) & 255);
  endfunction

  task automatic chk(string tag, longint act_v, longint exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (write index %0d)", tag, act_v, exp_v, kk);
    end
  endtask

  // Drive one clock's inputs and advance the reference model across that edge.
  task automatic drive(bit t);
    bit  lk [DEPTH];
    int  tgt, c, nxt;
    bit  acc, found;
    ev_t ev;
    for (int ch = 0; ch < NCH; ch++) samp_i[ch*8 +: 8] = pat(kk, ch);
    trig_i = t;
    for (int i = 0; i < DEPTH; i++) lk[i] = 1'b0;
    foreach (pend[i]) lk[pend[i].col] = 1'b1;
    if (m_act) lk[act_it.col] = 1'b1;
    tgt = (m_wr + DEPTH - (int'(lat_i) % DEPTH)) % DEPTH;      // R3
    acc = t && (pend.size() < DQ);                           // R4
    if (acc) lk[tgt] = 1'b1;                                 // R5
    if (t && !acc) m_ovf = 1'b1;
    ev.col = tgt;
    ev.k   = colk[tgt];
    colk[m_wr] = kk;                                         // R2
    found = 1'b0;
    nxt = m_wr;
    for (int s = 1; s <= DQ + 3; s++) begin
      c = (m_wr + s) % DEPTH;
      if (!found && !lk[c]) begin nxt = c; found = 1'b1; end
    end
    m_wr = nxt;
    if ((!m_act || m_cnt == FR - 1) && pend.size() > 0) begin  // R9 R11
      act_it = pend.pop_front();
      m_act = 1'b1;
      m_cnt = 0;
    end else if (m_act && m_cnt == FR - 1) begin
      m_act = 1'b0;
      m_cnt = 0;
    end else if (m_act) begin
      m_cnt++;
    end
    if (acc) pend.push_back(ev);
    kk++;
  endtask

  task automatic monitor();
    logic [7:0] ex;
    chk("R6 R9 lane_valid", lane_valid, m_act);
    chk("R10 busy", busy_o, (pend.size() > 0) || m_act);
    chk("R4 overflow", ovf_o, m_ovf);
    if (m_act) begin
      for (int l = 0; l < 4; l++) begin
        if (m_cnt < 4) begin
          ex = 8'((act_it.col >> (6 - 2 * m_cnt)) & 3);
          chk("R7 header", lane_dout[l*8 +: 8], ex);
        end else begin
          ex = pat(act_it.k, CPL * l + m_cnt - 4);
          chk("R2 R3 R5 R8 R11 sample", lane_dout[l*8 +: 8], ex);
        end
      end
    end
  endtask

  task automatic step(bit t);
    drive(t);
    @(negedge clk);
    monitor();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trig_i = 1'b0;
    pend.delete();
    m_act = 1'b0; m_cnt = 0; m_ovf = 1'b0; m_wr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", lane_valid, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset overflow", ovf_o, 0);
    chk("R1 reset lanes", lane_dout, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    samp_i = '0;
    lat_i = 8'd10;
    kk = 0;
    for (int i = 0; i < DEPTH; i++) colk[i] = -1;
    do_reset();
    idle(170);                          // fill every column (R2)
    step(1'b1); idle(60);               // single event, R6 latency of start
    lat_i = 8'd1;   step(1'b1); idle(40);
    lat_i = 8'd159; step(1'b1); idle(40);
    lat_i = 8'd20;                      // short burst: R9 back-to-back
    for (int i = 0; i < 5; i++) step(1'b1);
    idle(220);
    lat_i = 8'd50;                      // long burst: R4 overflow, R5 wrap-around locking
    for (int i = 0; i < 20; i++) step(1'b1);
    idle(700);
    chk("R4 overflow sticky", ovf_o, 1);
    lat_i = 8'd77;
    for (int i = 0; i < 2000; i++) step($urandom_range(0, 29) == 0);
    idle(700);
    do_reset();                         // R1 clears overflow
    lat_i = 8'd5;
    step(1'b1); step(1'b1); idle(120);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule